// File: doc/BRIEF.md
# PRBS31 Serial Test Pattern Source

This block is the test-pattern source that sits just in front of a high-speed serial transmitter. It produces a pseudorandom sequence with period 2^31-1, one bit per clock, from a 31-stage linear feedback shift register. It also chooses which bit goes out on each cycle: the pseudorandom bit, the bit of a second test pattern, or the normal traffic bit. The output is registered, so a change on any input shows at `data_o` one clock later.

The generator's natural output is the complement of the sequence that common lab instruments produce. An invert-select input flips the pseudorandom bit so that it matches those instruments. The register only advances on cycles where the PRBS enable is high. When the enable drops, the sequence pauses and then resumes where it stopped.

Top module: `prbs31_gen`

## Requirements
- R1: While `rst_ni` is low, `data_o` is 0 and the shift register is loaded with all ones. With `inv_sel_i` = 0, the first 28 PRBS bits after reset are therefore 1 and the 29th is 0.
- R2: On each clock edge with `prbs_en_i` = 1, the register computes the standard bit s = S30 xor S27, where S0 is the newest stage. It shifts one place toward S30 and loads s into S0. This implements 1 + x^28 + x^31.
- R3: With `prbs_en_i` = 1, `data_o` on the next cycle is the inverse of s when `inv_sel_i` = 0, and s itself when `inv_sel_i` = 1. The invert select has no effect on the other two sources.
- R4: When `prbs_en_i` and `test_en_i` are both 1, `data_o` carries the PRBS bit, whatever the value of `test_bit_i`.
- R5: With `prbs_en_i` = 0 and `test_en_i` = 1, `data_o` on the next cycle equals `test_bit_i`.
- R6: With both enables at 0, `data_o` on the next cycle equals `data_i`, unchanged.
- R7: With `prbs_en_i` = 0, the register holds its state. After re-enabling, the sequence continues from the bit that would have come next.
- R8: The register never holds all zeros, so the output never locks up at a constant value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prbs_en_i | input | 1 | Selects the PRBS and lets the register advance |
| test_en_i | input | 1 | Selects the secondary test pattern |
| test_bit_i | input | 1 | Secondary test pattern bit |
| inv_sel_i | input | 1 | 1 gives the instrument-polarity PRBS |
| data_i | input | 1 | Normal traffic bit |
| data_o | output | 1 | Serial bit to the transmitter |

## Verification
The bound checker checks the following on every cycle: the one-place shift and the feedback bit, the PRBS polarity on the output, the source priority, the pass-through of the test and traffic bits, the hold while disabled, and that the register is never zero. The bench alone shows the reset value, the seed (through the known run of 28 ones), long stretches of the sequence against a bench model that inverts on its own, and the exact point where the sequence resumes after a pause.

// File: rtl/prbs31_gen_pkg.sv
package prbs31_gen_pkg;
  localparam int unsigned LFSR_W = 31;
  localparam int unsigned TAP_LO = 27;
  localparam int unsigned TAP_HI = 30;
  localparam logic [LFSR_W-1:0] SEED = {LFSR_W{1'b1}};

  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_TEST = 2'd1,
    SRC_PRBS = 2'd2
  } src_e;
endpackage

// File: rtl/prbs31_lfsr.sv
module prbs31_lfsr #(
  parameter int unsigned W      = prbs31_gen_pkg::LFSR_W,
  parameter int unsigned TAP_LO = prbs31_gen_pkg::TAP_LO,
  parameter int unsigned TAP_HI = prbs31_gen_pkg::TAP_HI,
  parameter logic [W-1:0] SEED  = {W{1'b1}}
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic         std_bit_o,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q, nxt;
  logic         fb;

  always_comb begin
    fb  = q[TAP_HI] ^ q[TAP_LO];
    nxt = {q[W-2:0], fb};
    // lock-up guard: reseed if the zero state is ever reached
    if (nxt == '0) nxt = SEED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= SEED;
    else if (adv_i) q <= nxt;
  end

  assign std_bit_o = fb;
  assign state_o   = q;
endmodule

// File: rtl/prbs31_src_sel.sv
module prbs31_src_sel
  import prbs31_gen_pkg::*;
(
  input  logic prbs_en_i,
  input  logic test_en_i,
  output src_e src_o
);
  always_comb begin
    if (prbs_en_i)      src_o = SRC_PRBS;
    else if (test_en_i) src_o = SRC_TEST;
    else                src_o = SRC_DATA;
  end
endmodule

// File: rtl/prbs31_out_reg.sv
module prbs31_out_reg
  import prbs31_gen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e src_i,
  input  logic prbs_bit_i,
  input  logic test_bit_i,
  input  logic data_i,
  output logic data_o
);
  logic d;

  always_comb begin
    unique case (src_i)
      SRC_PRBS: d = prbs_bit_i;
      SRC_TEST: d = test_bit_i;
      default:  d = data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= 1'b0;
    else         data_o <= d;
  end
endmodule

// File: rtl/prbs31_gen.sv
module prbs31_gen
  import prbs31_gen_pkg::*;
#(
  parameter bit RAW_INVERT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prbs_en_i,
  input  logic test_en_i,
  input  logic test_bit_i,
  input  logic inv_sel_i,
  input  logic data_i,
  output logic data_o
);
  logic              std_bit;
  logic [LFSR_W-1:0] lfsr_state;
  logic              prbs_bit;
  src_e              src;

  prbs31_lfsr #(
    .W(LFSR_W), .TAP_LO(TAP_LO), .TAP_HI(TAP_HI), .SEED(SEED)
  ) i_lfsr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (prbs_en_i),
    .std_bit_o (std_bit),
    .state_o   (lfsr_state)
  );

  generate
    if (RAW_INVERT) begin : g_raw_inv
      assign prbs_bit = ~std_bit ^ inv_sel_i;
    end else begin : g_raw_std
      assign prbs_bit = std_bit ^ inv_sel_i;
    end
  endgenerate

  prbs31_src_sel i_sel (
    .prbs_en_i (prbs_en_i),
    .test_en_i (test_en_i),
    .src_o     (src)
  );

  prbs31_out_reg i_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src),
    .prbs_bit_i (prbs_bit),
    .test_bit_i (test_bit_i),
    .data_i     (data_i),
    .data_o     (data_o)
  );
endmodule

// File: rtl/prbs31_gen_chk.sv
module prbs31_gen_chk #(
  parameter int unsigned W = 31
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         prbs_en_i,
  input logic         test_en_i,
  input logic         test_bit_i,
  input logic         inv_sel_i,
  input logic         data_i,
  input logic         data_o,
  input logic         std_bit_i,
  input logic [W-1:0] state_i
);
  assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prbs_en_i |=> (state_i[W-1:1] == $past(state_i[W-2:0])) && (state_i[0] == $past(std_bit_i)));

  assert_polarity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prbs_en_i |=> data_o == ($past(std_bit_i) ^ ~$past(inv_sel_i)));

  assert_priority_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prbs_en_i && test_en_i) |=> (data_o == ($past(std_bit_i) ^ ~$past(inv_sel_i))) && !$stable(state_i));

  assert_test_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prbs_en_i && test_en_i) |=> data_o == $past(test_bit_i));

  assert_data_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prbs_en_i && !test_en_i) |=> data_o == $past(data_i));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prbs_en_i |=> $stable(state_i));

  assert_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != '0);
endmodule

bind prbs31_gen prbs31_gen_chk #(.W(prbs31_gen_pkg::LFSR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .prbs_en_i  (prbs_en_i),
  .test_en_i  (test_en_i),
  .test_bit_i (test_bit_i),
  .inv_sel_i  (inv_sel_i),
  .data_i     (data_i),
  .data_o     (data_o),
  .std_bit_i  (std_bit),
  .state_i    (lfsr_state)
);

// File: tb/test_prbs31_gen.sv
module test_prbs31_gen;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic prbs_en_i = 1'b0, test_en_i = 1'b0, test_bit_i = 1'b0;
  logic inv_sel_i = 1'b0, data_i = 1'b0;
  logic data_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [30:0] m = '1;   // bench model of the register
  logic        m_out = 1'b0;

  always #10 clk = ~clk;

  prbs31_gen i_prbs31_gen (
    .clk_i(clk), .rst_ni(rst_ni), .prbs_en_i(prbs_en_i), .test_en_i(test_en_i),
    .test_bit_i(test_bit_i), .inv_sel_i(inv_sel_i), .data_i(data_i), .data_o(data_o)
  );

  typedef struct packed {
    logic p, t, tb, d, inv, use_model, exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1},   // R6 data 1
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0},   // R6 data 0, inv ignored
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1},   // R5 test 1
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0},   // R5 test 0, inv ignored
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0},   // R2 prbs
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0},   // R4 both on
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0},   // R4 both on, inverted
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1},   // R5
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},   // R6
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0},   // R3 inverted
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0},   // R2
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1},   // R6
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0},   // R5
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0}    // R4
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: data_o=%b expected=%b", req, act, exp);
    end
  endtask

  // drive at negedge, model advances at posedge, caller samples at next negedge
  task automatic step(input logic p, t, tb, d, inv);
    logic s;
    prbs_en_i = p; test_en_i = t; test_bit_i = tb; data_i = d; inv_sel_i = inv;
    @(posedge clk);
    if (p) begin
      s = m[30] ^ m[27];
      m = {m[29:0], s};
      m_out = ~s ^ inv;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    prbs_en_i = 0; test_en_i = 0; test_bit_i = 0; data_i = 1; inv_sel_i = 0;
    rst_ni = 1'b0;
    m = '1;
    repeat (3) @(negedge clk);
    check("R1 reset value", data_o, 1'b0);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    int ones, zeros;
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].p, TBL[i].t, TBL[i].tb, TBL[i].d, TBL[i].inv);
      check("R2-table vector", data_o, TBL[i].use_model ? m_out : TBL[i].exp);
    end

    // R1: seed of all ones gives 28 raw ones then a zero
    do_reset();
    for (int i = 0; i < 29; i++) begin
      step(1, 0, 0, 0, 0);
      check("R1 seed run", data_o, (i < 28) ? 1'b1 : 1'b0);
    end

    // R2: long stretch against model, raw polarity (R3)
    for (int i = 0; i < 3000; i++) begin
      step(1, 0, 0, 0, 0);
      check("R2 sequence", data_o, m_out);
    end

    // R3: instrument polarity
    for (int i = 0; i < 200; i++) begin
      step(1, 0, 0, 0, 1);
      check("R3 inverted output", data_o, m_out);
    end

    // R4: test bit set to the opposite of the PRBS bit
    for (int i = 0; i < 100; i++) begin
      logic nb;
      nb = m[30] ^ m[27];   // standard bit; raw output is ~nb, so feed nb as test bit
      step(1, 1, nb, nb, 0);
      check("R4 priority", data_o, m_out);
    end

    // R7: pause with traffic and test pattern, then resume
    for (int i = 0; i < 25; i++) begin
      step(0, i[0], i[1], i[2], 1);
      check("R7 paused output", data_o, i[0] ? i[1] : i[2]);
    end
    for (int i = 0; i < 100; i++) begin
      step(1, 0, 0, 0, 0);
      check("R7 resume", data_o, m_out);
    end

    // R8: output not stuck over a long run
    ones = 0; zeros = 0;
    for (int i = 0; i < 500; i++) begin
      step(1, 0, 0, 0, 0);
      if (data_o) ones++; else zeros++;
    end
    check("R8 no lock-up (ones seen)", ones > 0, 1'b1);
    check("R8 no lock-up (zeros seen)", zeros > 0, 1'b1);

    finish_run();
  end
endmodule